// File: doc/BRIEF.md
# Bidirectional Open-Drain Reset Pin Controller

This block sequences chip-level reset around a single active-low, open-drain reset pin. The pin serves both as an input and as an output. When an outside device pulls the pin low long enough, the block accepts it as a hardware reset. It holds the internal reset while the pin stays low, then runs a fixed-length hardware reset tail once the pin returns high.

A software reset request or a watchdog reset request starts an internal reset pulse of fixed length. A watchdog request always pulls the pin low for that pulse. A software request pulls it low only when its pin-enable input is set. After a driven pulse, the block releases the pin and re-samples it once the synchroniser has settled. If something outside still holds the pin low at that point, the event becomes a hardware reset.

A second watchdog event, with no hardware or power-on reset between the two, locks the chip in reset. A small cause register records which kind of event came last.

Top module: `reset_pin_ctrl`

## Requirements
- R1: A low level on `pin_i` starts a hardware reset only when it is seen in two consecutive synchronised samples. A pin low at a single clock edge is ignored. A qualifying low raises `sys_rst_o` four clock edges after the pin first goes low.
- R2: An accepted software request with `sw_pin_en_i`=1 asserts `pin_oe_o` for exactly 16 cycles.
- R3: An accepted software request with `sw_pin_en_i`=0 never asserts `pin_oe_o` and holds `sys_rst_o` for exactly 16 cycles.
- R4: A first watchdog request asserts `pin_oe_o` for exactly 16 cycles.
- R5: After a driven pulse the pin is released and `sys_rst_o` stays high for 3 more cycles, 19 cycles in total. If the synchronised pin is still low at the end of those 3 cycles, a hardware reset sequence follows.
- R6: While `rst_ni` is low, `sys_rst_o`=1, `pin_oe_o`=0 and `cause_o`=0. After `rst_ni` rises, `sys_rst_o` stays high as long as the pin is low. It falls three clock edges after the pin goes high.
- R7: `pin_oe_o` is never asserted during a hardware reset sequence. The sequence ends, and `sys_rst_o` falls, ten clock edges after the pin returns high (two for synchronisation, then eight).
- R8: The hardware cause flag, `cause_o` bit 0, is set only when a hardware reset sequence completes.
- R9: A watchdog request while an earlier watchdog event is remembered locks `sys_rst_o` high with no pin drive, and all requests are ignored. Only a qualified external low (a hardware reset) or `rst_ni` clears the lock and the remembered event.
- R10: `cause_o` is one-hot or zero: bit 0 hardware, bit 1 software, bit 2 watchdog. Each new event overwrites it. A watchdog request wins over a software request in the same cycle. Only `rst_ni` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| pin_i | input | 1 | Sampled level of the reset pin |
| sw_req_i | input | 1 | Software reset request, one-cycle strobe |
| sw_pin_en_i | input | 1 | Software reset also drives the pin |
| wdt_req_i | input | 1 | Watchdog reset request, one-cycle strobe |
| pin_oe_o | output | 1 | Pin drive enable; the pin data is fixed at 0 |
| sys_rst_o | output | 1 | Internal chip reset, active high |
| cause_o | output | 3 | Last reset cause, one-hot |

## Verification
Every result has a known latency from its stimulus:
- A pin low reaches the state machine after two synchroniser edges and is qualified one edge later, so `sys_rst_o` rises on the fourth edge.
- A request strobe sampled at an edge enters the pulse state at that edge. The bench then counts `pin_oe_o` and `sys_rst_o` cycles until reset falls and compares the totals (16, 16 or 19).
- Pin releases are timed in edges: three edges out of power-on reset, ten edges out of a hardware sequence.

The bench drives inputs and samples outputs on the falling clock edge, so every count lines up with these rising-edge latencies.

// File: rtl/reset_pin_pkg.sv
package reset_pin_pkg;
  typedef enum logic [2:0] {
    ST_POR   = 3'd0,
    ST_RUN   = 3'd1,
    ST_PULSE = 3'd2,
    ST_CHECK = 3'd3,
    ST_HW    = 3'd4,
    ST_LOCK  = 3'd5
  } rst_state_e;

  localparam int CAUSE_W   = 3;
  localparam int CAUSE_HW  = 0;
  localparam int CAUSE_SW  = 1;
  localparam int CAUSE_WDT = 2;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES   = 2,
  parameter int QUAL_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_s_o,
  output logic qual_o
);
  localparam int QW = $clog2(QUAL_LEN + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_LEN - 1);

  logic [STAGES-1:0] sync_q;
  logic [QW-1:0]     lo_cnt_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign pin_s_o = sync_q[STAGES-1];

  // consecutive low samples, saturating
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              lo_cnt_q <= '0;
    else if (pin_s_o)         lo_cnt_q <= '0;
    else if (lo_cnt_q != QMAX) lo_cnt_q <= lo_cnt_q + 1'b1;

  assign qual_o = !pin_s_o && (lo_cnt_q >= QMAX);

  assert_qual_two_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_o |-> (!pin_s_o && !$past(pin_s_o)));
endmodule

// File: rtl/reset_seq_fsm.sv
module reset_seq_fsm
  import reset_pin_pkg::*;
#(
  parameter int PULSE_LEN = 16,
  parameter int HW_LEN    = 8,
  parameter int SETTLE    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  input  logic qual_i,
  input  logic sw_req_i,
  input  logic sw_pin_en_i,
  input  logic wdt_req_i,
  output logic pin_oe_o,
  output logic sys_rst_o,
  output logic ev_hw_o,
  output logic ev_sw_o,
  output logic ev_wdt_o
);
  localparam int MAXV  = (PULSE_LEN > HW_LEN) ?
                         ((PULSE_LEN > SETTLE + 1) ? PULSE_LEN : SETTLE + 1) :
                         ((HW_LEN > SETTLE + 1) ? HW_LEN : SETTLE + 1);
  localparam int CNT_W = $clog2(MAXV + 1);
  localparam logic [CNT_W-1:0] PULSE_END  = CNT_W'(PULSE_LEN - 1);
  localparam logic [CNT_W-1:0] HW_END     = CNT_W'(HW_LEN - 1);
  localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE);

  rst_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             drv_q, drv_d;
  logic             seen_q, seen_d;   // one watchdog event remembered

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    drv_d    = drv_q;
    seen_d   = seen_q;
    ev_hw_o  = 1'b0;
    ev_sw_o  = 1'b0;
    ev_wdt_o = 1'b0;
    unique case (state_q)
      ST_POR: if (pin_s_i) state_d = ST_RUN;
      ST_RUN: begin
        if (wdt_req_i) begin
          ev_wdt_o = 1'b1;
          if (seen_q) state_d = ST_LOCK;
          else begin
            seen_d  = 1'b1;
            drv_d   = 1'b1;
            cnt_d   = '0;
            state_d = ST_PULSE;
          end
        end else if (sw_req_i) begin
          ev_sw_o = 1'b1;
          drv_d   = sw_pin_en_i;
          cnt_d   = '0;
          state_d = ST_PULSE;
        end else if (qual_i) begin
          cnt_d   = '0;
          state_d = ST_HW;
        end
      end
      ST_PULSE: begin
        if (cnt_q == PULSE_END) begin
          cnt_d   = '0;
          state_d = drv_q ? ST_CHECK : ST_RUN;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_CHECK: begin
        // released pin needs SETTLE edges to reach the sampled level
        if (cnt_q == SETTLE_END) begin
          cnt_d   = '0;
          state_d = pin_s_i ? ST_RUN : ST_HW;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_HW: begin
        if (!pin_s_i) cnt_d = '0;
        else if (cnt_q == HW_END) begin
          ev_hw_o = 1'b1;
          seen_d  = 1'b0;
          state_d = ST_RUN;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_LOCK: if (qual_i) begin
        cnt_d   = '0;
        state_d = ST_HW;
      end
      default: state_d = ST_POR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_POR;
      cnt_q   <= '0;
      drv_q   <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      drv_q   <= drv_d;
      seen_q  <= seen_d;
    end

  assign pin_oe_o  = (state_q == ST_PULSE) && drv_q;
  assign sys_rst_o = (state_q != ST_RUN);

  // run length of pin drive, for checking only
  logic [CNT_W-1:0] oe_run_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       oe_run_q <= '0;
    else if (pin_oe_o) oe_run_q <= oe_run_q + 1'b1;
    else               oe_run_q <= '0;

  assert_pulse_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_oe_o) |-> (oe_run_q == CNT_W'(PULSE_LEN)));
  assert_internal_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && sw_req_i && !sw_pin_en_i && !wdt_req_i) |=> !pin_oe_o);
  assert_no_drive_hw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HW || state_q == ST_POR || state_q == ST_LOCK) |-> !pin_oe_o);
  assert_lock_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCK && !qual_i) |=> (sys_rst_o && !pin_oe_o));
endmodule

// File: rtl/cause_log.sv
module cause_log
  import reset_pin_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ev_hw_i,
  input  logic               ev_sw_i,
  input  logic               ev_wdt_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q;

  // latest event overwrites; watchdog beats software beats hardware
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       cause_q <= '0;
    else if (ev_wdt_i) cause_q <= CAUSE_W'(1) << CAUSE_WDT;
    else if (ev_sw_i)  cause_q <= CAUSE_W'(1) << CAUSE_SW;
    else if (ev_hw_i)  cause_q <= CAUSE_W'(1) << CAUSE_HW;

  assign cause_o = cause_q;

  assert_cause_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_o));
  assert_hw_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_hw_i && !ev_sw_i && !ev_wdt_i) |=> cause_o[CAUSE_HW]);
endmodule

// File: rtl/reset_pin_ctrl.sv
module reset_pin_ctrl
  import reset_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_LEN    = 2,
  parameter int PULSE_LEN   = 16,
  parameter int HW_LEN      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pin_i,
  input  logic               sw_req_i,
  input  logic               sw_pin_en_i,
  input  logic               wdt_req_i,
  output logic               pin_oe_o,
  output logic               sys_rst_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int SETTLE = SYNC_STAGES;

  logic pin_s, qual, ev_hw, ev_sw, ev_wdt;

  pin_sync #(.STAGES(SYNC_STAGES), .QUAL_LEN(QUAL_LEN)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i),
    .pin_s_o(pin_s), .qual_o(qual)
  );

  reset_seq_fsm #(.PULSE_LEN(PULSE_LEN), .HW_LEN(HW_LEN), .SETTLE(SETTLE)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_s_i(pin_s), .qual_i(qual),
    .sw_req_i(sw_req_i), .sw_pin_en_i(sw_pin_en_i), .wdt_req_i(wdt_req_i),
    .pin_oe_o(pin_oe_o), .sys_rst_o(sys_rst_o),
    .ev_hw_o(ev_hw), .ev_sw_o(ev_sw), .ev_wdt_o(ev_wdt)
  );

  cause_log u_cause (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ev_hw_i(ev_hw), .ev_sw_i(ev_sw), .ev_wdt_i(ev_wdt),
    .cause_o(cause_o)
  );

  assert_drive_in_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o |-> sys_rst_o);
endmodule

// File: tb/sim_reset_pin_ctrl.sv
module sim_reset_pin_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  // {sw, pin_en, wdt, exp_oe_cycles, exp_rst_cycles, exp_cause}
  localparam int VEC [NV][6] = '{
    '{1, 1, 0, 16, 19, 2},
    '{1, 0, 0,  0, 16, 2},
    '{1, 1, 1, 16, 19, 4},
    '{1, 0, 0,  0, 16, 2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_low = 1'b0;
  logic sw_req = 1'b0, sw_en = 1'b0, wdt_req = 1'b0;
  logic pin_oe, sys_rst;
  logic [2:0] cause;
  logic pin_w;
  int n_tests = 0, n_fail = 0;

  assign pin_w = !(pin_oe || ext_low);  // open drain with pull-up

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_pin_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin_w),
    .sw_req_i(sw_req), .sw_pin_en_i(sw_en), .wdt_req_i(wdt_req),
    .pin_oe_o(pin_oe), .sys_rst_o(sys_rst), .cause_o(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_req(input logic s, input logic e, input logic w,
                         output int oe_n, output int rst_n_cyc);
    oe_n = 0; rst_n_cyc = 0;
    sw_req = s; sw_en = e; wdt_req = w;
    @(negedge clk);
    sw_req = 0; sw_en = 0; wdt_req = 0;
    for (int g = 0; g < 2000 && sys_rst; g++) begin
      if (pin_oe) oe_n++;
      rst_n_cyc++;
      @(negedge clk);
    end
  endtask

  task automatic wait_release(output int n);
    n = 0;
    for (int g = 0; g < 500; g++) begin
      @(negedge clk);
      n++;
      if (!sys_rst) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int oe_n, rc, n, hi;
    repeat (3) @(negedge clk);
    chk("R6 reset sys_rst", sys_rst, 1);
    chk("R6 reset oe", pin_oe, 0);
    chk("R10 reset cause", cause, 0);

    // R6: pin held low past power-on reset
    ext_low = 1; rst_n = 1;
    repeat (20) @(negedge clk);
    chk("R6 held by pin", sys_rst, 1);
    ext_low = 0;
    repeat (2) @(negedge clk);
    chk("R6 still in reset after 2 edges", sys_rst, 1);
    @(negedge clk);
    chk("R6 released after 3 edges", sys_rst, 0);

    // R1: single-edge glitch ignored
    ext_low = 1;
    @(negedge clk);
    ext_low = 0;
    hi = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (sys_rst) hi++; end
    chk("R1 glitch ignored", hi, 0);

    // R1/R7/R8: qualified external reset
    ext_low = 1;
    repeat (3) @(negedge clk);
    chk("R1 not yet after 3 edges", sys_rst, 0);
    @(negedge clk);
    chk("R1 reset after 4 edges", sys_rst, 1);
    hi = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (pin_oe) hi++; end
    chk("R7 no drive in hw sequence", hi, 0);
    chk("R8 flag not before completion", cause, 0);
    ext_low = 0;
    wait_release(n);
    chk("R7 hw sequence length", n, 10);
    chk("R8 hw cause flag", cause, 1);

    // R2 R3 R4 R10: request table
    for (int v = 0; v < NV; v++) begin
      repeat (2) @(negedge clk);
      run_req(VEC[v][0][0], VEC[v][1][0], VEC[v][2][0], oe_n, rc);
      chk("R2 R3 R4 drive cycles", oe_n, VEC[v][3]);
      chk("R3 R5 reset cycles", rc, VEC[v][4]);
      chk("R10 cause", cause, VEC[v][5]);
    end

    // R9: second watchdog locks
    repeat (2) @(negedge clk);
    wdt_req = 1;
    @(negedge clk);
    wdt_req = 0;
    sw_req = 1; sw_en = 1;
    @(negedge clk);
    sw_req = 0; sw_en = 0;
    hi = 0; n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pin_oe) hi++;
      if (sys_rst) n++;
    end
    chk("R9 lock no drive", hi, 0);
    chk("R9 lock holds reset", n, 100);
    chk("R9 R10 cause watchdog", cause, 4);
    ext_low = 1;
    repeat (5) @(negedge clk);
    ext_low = 0;
    wait_release(n);
    chk("R9 hw reset clears lock", sys_rst, 0);
    chk("R8 cause after lock exit", cause, 1);
    repeat (2) @(negedge clk);
    run_req(0, 0, 1, oe_n, rc);
    chk("R9 watchdog memory cleared", oe_n, 16);
    chk("R4 watchdog reset cycles", rc, 19);

    // R5: pin still held at release
    repeat (2) @(negedge clk);
    sw_req = 1; sw_en = 1;
    @(negedge clk);
    sw_req = 0; sw_en = 0;
    repeat (5) @(negedge clk);
    ext_low = 1;
    repeat (30) @(negedge clk);
    chk("R5 held becomes hw reset", sys_rst, 1);
    chk("R5 released pin", pin_oe, 0);
    chk("R5 cause before completion", cause, 2);
    ext_low = 0;
    wait_release(n);
    chk("R5 hw tail length", n, 10);
    chk("R5 R8 cause hardware", cause, 1);

    // R9 R10: lock cleared by power-on reset
    repeat (2) @(negedge clk);
    run_req(0, 0, 1, oe_n, rc);
    chk("R4 first watchdog", oe_n, 16);
    run_req(0, 0, 1, oe_n, rc);
    chk("R9 second watchdog locks", rc, 2000);
    rst_n = 0;
    @(negedge clk);
    chk("R10 por clears cause", cause, 0);
    chk("R6 por reset", sys_rst, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R6 por release", sys_rst, 0);
    run_req(0, 0, 1, oe_n, rc);
    chk("R9 por clears watchdog memory", oe_n, 16);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule